// File: doc/BRIEF.md
# Clock Reference Selection Controller

This controller decides which of two reference clock inputs a downstream PLL tracks, and in which of three operating states that PLL runs: Free-run, Lock or Holdover. Each input arrives with a valid flag; a flag at 0 means loss of signal. A flag must stay high for a programmable number of cycles before the input counts as qualified. The PLL only enters Lock on a qualified input.

In automatic mode, the controller prefers input 0. When the tracked input fails, it moves to the other input if that one is qualified; otherwise it goes to Holdover. Revertive operation is optional. In manual mode, the choice comes from a register bit or from a synchronised, debounced select pin. Only the chosen input is used, and if it fails the controller goes to Holdover and does not fail over. A single-cycle event pulse and a sticky event bit report every change of state, selection or input flags. The sticky bit is cleared by a write-one strobe.

All pins are plain control and status levels. The block has no streaming interface, so it has no back-pressure rules.

Top module: `refsel_ctrl`

## Requirements
- R1: After reset, pll_state is 2'b00 (Free-run), sel_ref is 0, and locked, holdover, irq_pulse and irq_sticky are all 0. pll_state never takes the value 2'b11.
- R2: An input is qualified only after its valid flag has been sampled high on qual_cnt consecutive clock edges. From Free-run with one input valid, locked rises after qual_cnt+1 edges. A drop in the flag restarts the count.
- R3: In automatic mode (mode 2'b00), the controller locks on input 0 when input 0 is qualified, and on input 1 when only input 1 is qualified. It stays in Free-run while neither input is qualified.
- R4: In automatic mode in Lock, a loss of the tracked input while the other input is qualified switches sel_ref to the other input on the next edge, and the state stays Lock (2'b01).
- R5: In automatic mode in Lock, a loss of the tracked input while the other input is not qualified enters Holdover (2'b10) on the next edge. In Holdover, holdover is 1 and locked is 0.
- R6: With revert_en at 1, a controller locked on input 1 returns to input 0 on the edge after input 0 is qualified. With revert_en at 0, it stays on input 1.
- R7: In manual register mode (mode 2'b01), only the input named by reg_sel is used. A loss of that input enters Holdover, and sel_ref does not change, even when the other input is valid.
- R8: In manual mode, a change of the manual choice moves sel_ref to it on the next edge. The state is Lock if the new input is qualified and Holdover otherwise.
- R9: In manual pin mode (mode[1] at 1), sel_pin at 0 selects input 0 and at 1 selects input 1. A pin change reaches sel_ref 7 edges after it is applied: 2 synchroniser stages, 4 stable samples, then 1 selection edge. A pulse held for 3 cycles or fewer is ignored.
- R10: From Holdover, the controller returns to Lock once an eligible input is qualified.
- R11: irq_pulse is high for exactly one cycle after the edge on which pll_state, sel_ref or the registered valid flags change.
- R12: irq_sticky is set by irq_pulse and cleared by irq_clr. When both happen on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Per-input valid flag (0 = loss of signal) |
| mode | input | 2 | 00 automatic, 01 manual by register, 1x manual by pin |
| revert_en | input | 1 | Revertive automatic switching |
| reg_sel | input | 1 | Register choice of input in manual register mode |
| sel_pin | input | 1 | Asynchronous clock-select pin |
| qual_cnt | input | QUAL_W | Qualify time in cycles |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq_sticky |
| sel_ref | output | 1 | Index of the tracked input |
| pll_state | output | 2 | 00 Free-run, 01 Lock, 10 Holdover |
| locked | output | 1 | State is Lock |
| holdover | output | 1 | State is Holdover |
| irq_pulse | output | 1 | Single-cycle event pulse |
| irq_sticky | output | 1 | Sticky event bit |

## Verification
The bench builds the block with QUAL_W = 4 and SEL_STABLE = 4, so the qualify timer and the pin debouncer stay short enough to step through edge by edge.

It sweeps qual_cnt from 0 to 6 and compares the lock latency with the computed qual_cnt+1. It also sweeps all four valid-flag patterns for the automatic choice of input.

The pin path is checked both ways at its exact 7-edge latency, and a 3-cycle glitch is shown to be ignored.

The set-over-clear race of the sticky bit is provoked on purpose.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'b00,
    ST_LOCK = 2'b01,
    ST_HOLD = 2'b10
  } pll_st_e;

  localparam logic [1:0] MODE_AUTO = 2'b00;
endpackage

// File: rtl/refsel_qual.sv
module refsel_qual #(
  parameter int QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_ok,
  input  logic [QUAL_W-1:0] limit,
  output logic              qualified
);
  localparam logic [QUAL_W-1:0] SAT = '1;

  logic [QUAL_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)             run_len <= '0;
    else if (!sig_ok)       run_len <= '0;
    else if (run_len != SAT) run_len <= run_len + 1'b1;
  end

  assign qualified = sig_ok && (run_len >= limit);

  // R2: a nonzero qualify time needs the flag seen high before
  a_r2_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
    (qualified && limit != '0) |-> $past(sig_ok));
endmodule

// File: rtl/refsel_pinsync.sv
module refsel_pinsync #(
  parameter int SEL_STABLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_sel
);
  localparam int CW = $clog2(SEL_STABLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SEL_STABLE - 1);

  logic          s1, s2;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      hold_cnt <= '0;
      pin_sel <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      if (s2 != pin_sel) begin
        if (hold_cnt == LAST) begin
          pin_sel  <= s2;
          hold_cnt <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end else begin
        hold_cnt <= '0;
      end
    end
  end

  // R9: debounced value only ever moves to the synchronised pin level
  a_r9_pin_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel != $past(pin_sel)) |-> (pin_sel == $past(s2)));
endmodule

// File: rtl/refsel_irq.sv
module refsel_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] state,
  input  logic       sel,
  input  logic [1:0] flags,
  input  logic       clr,
  output logic       pulse,
  output logic       sticky
);
  logic [1:0] st_d, fl_q, fl_d;
  logic       sel_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_d   <= 2'b00;
      sel_d  <= 1'b0;
      fl_q   <= 2'b00;
      fl_d   <= 2'b00;
      sticky <= 1'b0;
    end else begin
      st_d   <= state;
      sel_d  <= sel;
      fl_q   <= flags;
      fl_d   <= fl_q;
      sticky <= pulse | (sticky & ~clr);
    end
  end

  assign pulse = (state != st_d) || (sel != sel_d) || (fl_q != fl_d);

  // R11: a state change is reported in the following cycle
  a_r11_state_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> pulse);
  // R12: a pulse always leaves the sticky bit set
  a_r12_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> sticky);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int QUAL_W     = 4,
  parameter int SEL_STABLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        in_valid,
  input  logic [1:0]        mode,
  input  logic              revert_en,
  input  logic              reg_sel,
  input  logic              sel_pin,
  input  logic [QUAL_W-1:0] qual_cnt,
  input  logic              irq_clr,
  output logic              sel_ref,
  output logic [1:0]        pll_state,
  output logic              locked,
  output logic              holdover,
  output logic              irq_pulse,
  output logic              irq_sticky
);
  import refsel_pkg::*;

  localparam int NIN = 2;

  logic [NIN-1:0] qual;
  logic           pin_sel, man_sel, auto_md;
  pll_st_e        st, nst;
  logic           sel, nsel;

  for (genvar i = 0; i < NIN; i++) begin : g_qual
    refsel_qual #(.QUAL_W(QUAL_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .sig_ok(in_valid[i]),
      .limit(qual_cnt), .qualified(qual[i]));
  end

  refsel_pinsync #(.SEL_STABLE(SEL_STABLE)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(sel_pin), .pin_sel(pin_sel));

  assign auto_md = (mode == MODE_AUTO);
  assign man_sel = mode[1] ? pin_sel : reg_sel;

  always_comb begin
    nst  = st;
    nsel = sel;
    case (st)
      ST_FREE, ST_HOLD: begin
        if (auto_md) begin
          if (qual[0]) begin
            nst = ST_LOCK; nsel = 1'b0;
          end else if (qual[1]) begin
            nst = ST_LOCK; nsel = 1'b1;
          end
        end else begin
          nsel = man_sel;
          if (qual[man_sel]) nst = ST_LOCK;
        end
      end
      ST_LOCK: begin
        if (auto_md) begin
          if (!in_valid[sel]) begin
            if (qual[!sel]) nsel = !sel;
            else            nst  = ST_HOLD;
          end else if (revert_en && sel && qual[0]) begin
            nsel = 1'b0;
          end
        end else begin
          if (man_sel != sel) begin
            nsel = man_sel;
            if (!qual[man_sel]) nst = ST_HOLD;
          end else if (!in_valid[sel]) begin
            nst = ST_HOLD;
          end
        end
      end
      default: nst = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_FREE;
      sel <= 1'b0;
    end else begin
      st  <= nst;
      sel <= nsel;
    end
  end

  assign sel_ref   = sel;
  assign pll_state = st;
  assign locked    = (st == ST_LOCK);
  assign holdover  = (st == ST_HOLD);

  refsel_irq u_irq (
    .clk(clk), .rst_n(rst_n), .state(pll_state), .sel(sel),
    .flags(in_valid), .clr(irq_clr), .pulse(irq_pulse), .sticky(irq_sticky));

  // R1: only the three defined state codes occur
  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    pll_state != 2'b11);
  // R1: Free-run is never re-entered once left
  a_r1_free_once: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_state != 2'b00) |=> (pll_state != 2'b00));
  // R4: automatic failover keeps Lock and flips the index
  a_r4_auto_failover: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && auto_md && !in_valid[sel] && qual[!sel])
      |=> (locked && sel_ref != $past(sel_ref)));
  // R5: automatic loss with no backup goes to Holdover
  a_r5_auto_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && auto_md && !in_valid[sel] && !qual[!sel]) |=> holdover);
  // R7: manual mode never moves the index without a new choice
  a_r7_manual_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !auto_md && man_sel == sel) |=> (sel_ref == $past(sel_ref)));
endmodule

// File: tb/tb_refsel_ctrl.sv
module tb_refsel_ctrl;
  localparam int QW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    in_valid = 2'b00;
  logic [1:0]    mode = 2'b00;
  logic          revert_en = 1'b0;
  logic          reg_sel = 1'b0;
  logic          sel_pin = 1'b0;
  logic [QW-1:0] qual_cnt = '0;
  logic          irq_clr = 1'b0;
  logic          sel_ref, locked, holdover, irq_pulse, irq_sticky;
  logic [1:0]    pll_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  refsel_ctrl #(.QUAL_W(QW), .SEL_STABLE(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .revert_en(revert_en), .reg_sel(reg_sel), .sel_pin(sel_pin),
    .qual_cnt(qual_cnt), .irq_clr(irq_clr), .sel_ref(sel_ref),
    .pll_state(pll_state), .locked(locked), .holdover(holdover),
    .irq_pulse(irq_pulse), .irq_sticky(irq_sticky));

  always #4 clk = ~clk;

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 2'b00; mode = 2'b00; revert_en = 1'b0;
    reg_sel = 1'b0; sel_pin = 1'b0; irq_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wait_lock(output int n);
    n = 0;
    while (!locked && n < 30) begin step(1); n++; end
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    // R1 reset state
    do_reset();
    chk(pll_state, 0, "R1 state");
    chk(sel_ref, 0, "R1 sel");
    chk(locked, 0, "R1 locked");
    chk(holdover, 0, "R1 holdover");
    chk(irq_pulse, 0, "R1 pulse");
    chk(irq_sticky, 0, "R1 sticky");

    // R2 qualify latency sweep: lock after qual_cnt+1 edges
    for (int q = 0; q <= 6; q++) begin
      do_reset();
      qual_cnt = QW'(q);
      in_valid = 2'b01;
      wait_lock(n);
      chk(n, q + 1, "R2 lock latency");
    end
    // R2 interrupted flag restarts the count
    do_reset();
    qual_cnt = 4'd3;
    in_valid = 2'b01; step(2);
    in_valid = 2'b00; step(1);
    chk(pll_state, 0, "R2 still free after gap");
    in_valid = 2'b01;
    wait_lock(n);
    chk(n, 4, "R2 restart latency");

    // R3 automatic choice over all flag patterns
    for (int v = 0; v < 4; v++) begin
      do_reset();
      qual_cnt = 4'd2;
      in_valid = 2'(v);
      step(6);
      chk(locked, (v != 0) ? 1 : 0, "R3 locked");
      chk(sel_ref, (v == 2) ? 1 : 0, "R3 sel");
    end

    // R4 failover: locked on 0 with both valid, input 0 lost
    do_reset();
    qual_cnt = 4'd2;
    in_valid = 2'b11; step(6);
    in_valid = 2'b10; step(1);
    chk(pll_state, 1, "R4 stays lock");
    chk(sel_ref, 1, "R4 switched to 1");

    // R6 non-revertive then revertive
    in_valid = 2'b11; step(10);
    chk(sel_ref, 1, "R6 non-revertive stays");
    revert_en = 1'b1; step(1);
    chk(sel_ref, 0, "R6 revertive returns to 0");
    revert_en = 1'b0;

    // R5 loss of both goes to Holdover
    in_valid = 2'b00; step(1);
    chk(pll_state, 2, "R5 holdover state");
    chk(holdover, 1, "R5 holdover flag");
    chk(locked, 0, "R5 locked low");

    // R10 return from Holdover once qualified
    in_valid = 2'b10; step(2);
    chk(holdover, 1, "R10 not yet qualified");
    step(1);
    chk(locked, 1, "R10 relocked");
    chk(sel_ref, 1, "R10 on input 1");

    // R7 manual register: no failover
    do_reset();
    qual_cnt = 4'd0;
    mode = 2'b01; reg_sel = 1'b1; in_valid = 2'b11;
    step(1);
    chk(locked, 1, "R7 locked");
    chk(sel_ref, 1, "R7 on chosen input");
    in_valid = 2'b01; step(5);
    chk(pll_state, 2, "R7 holdover not switch");
    chk(sel_ref, 1, "R7 sel unchanged");

    // R8 manual command
    reg_sel = 1'b0; step(1);
    chk(pll_state, 1, "R8 lock on new choice");
    chk(sel_ref, 0, "R8 sel follows reg");
    reg_sel = 1'b1; step(1);
    chk(sel_ref, 1, "R8 sel to unqualified input");
    chk(pll_state, 2, "R8 holdover on unqualified");

    // R9 pin mode latency and glitch rejection
    do_reset();
    mode = 2'b10; in_valid = 2'b11; step(1);
    chk(sel_ref, 0, "R9 pin 0 selects input 0");
    sel_pin = 1'b1;
    n = 0;
    while (sel_ref != 1'b1 && n < 30) begin step(1); n++; end
    chk(n, 7, "R9 rise latency");
    sel_pin = 1'b0; step(3);
    sel_pin = 1'b1; step(12);
    chk(sel_ref, 1, "R9 glitch ignored");
    sel_pin = 1'b0;
    n = 0;
    while (sel_ref != 1'b0 && n < 30) begin step(1); n++; end
    chk(n, 7, "R9 fall latency");

    // R11 pulse width, R12 sticky clear and set-wins
    do_reset();
    step(2);
    chk(irq_pulse, 0, "R11 quiet");
    in_valid = 2'b01; step(1);
    chk(irq_pulse, 1, "R11 pulse on change");
    step(1);
    chk(irq_pulse, 0, "R11 single cycle");
    chk(irq_sticky, 1, "R12 sticky set");
    irq_clr = 1'b1; step(1);
    chk(irq_sticky, 0, "R12 cleared");
    in_valid = 2'b00; step(1);
    chk(irq_pulse, 1, "R11 pulse on loss");
    step(1);
    chk(irq_sticky, 1, "R12 set wins over clear");
    irq_clr = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule